// File: doc/BRIEF.md
# Configurable Bidirectional Pad Cell Bank

This block is a row of pad cells. Each cell sits between one output of a logic block and one package pin. Each cell has its own configuration, which picks one of three roles: a pin that only listens, a pin that always drives, or a two-way pin whose driver is switched by an enable. The configuration also picks the driver style. A push-pull driver forces both levels. An open-drain driver can only pull the pin low and otherwise leaves it to an external pull-up resistor.

The driver enable of a cell has two possible sources. One is the cell's own product-term enable. The other is that enable gated by a chip-wide output-enable line, which is active high. A per-cell bit chooses between the two. Whatever the role, the level seen on the pin always comes back out of the block, so that the routing fabric can use any pin as an input. The pin is modelled as a tri-state net.

The configuration is held in registers. It is written as a whole bank in one clock cycle. Reset returns every cell to its erased setting: listen-only, push-pull, gated by the chip-wide enable.

Top module: `io_cell_bank`

## Requirements
- R1: A cell in listen-only mode never drives its pin. The mode field is `cfgMode[2i+1:2i]` for cell i. Listen-only is code 2'b11, and the spare code 2'b00 behaves the same way.
- R2: A cell in drive-only mode (code 2'b01) ignores its product-term enable. It drives whenever its gate-select bit `cfgOeSel[i]` is 0, and also when that bit is 1 and `globalOe` is 1.
- R3: A cell in two-way mode (code 2'b10) drives only when `ptOe[i]` is 1 and either `cfgOeSel[i]` is 0 or `globalOe` is 1.
- R4: When the style bit `cfgTotem[i]` is 1 (push-pull) and the cell is driving, the pin level equals `outData[i]`.
- R5: When `cfgTotem[i]` is 0 (open-drain) and the cell is driving, a data 0 pulls the pin low and a data 1 releases it. The cell never drives the pin high.
- R6: When the cell's enable is false, the pin is high impedance in both driver styles. It then shows the external level, or the pull-up when nothing else drives it.
- R7: `padIn[i]` always reports the level on pin i, in every mode, including the levels that the cell drives itself.
- R8: While `rstN` is low, and after it is released until the first load, every cell uses the erased setting: mode 2'b11, style 1, gate-select 1.
- R9: The configuration inputs are captured at a rising clock edge when `cfgLoad` is 1. At any edge where `cfgLoad` is 0, changing those inputs has no effect on the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rstN | input | 1 | Active-low asynchronous reset to the erased setting |
| cfgLoad | input | 1 | Capture the configuration inputs at this edge |
| cfgMode | input | 2*CELLS | Per-cell role code, two bits per cell |
| cfgTotem | input | CELLS | Per-cell driver style: 1 push-pull, 0 open-drain |
| cfgOeSel | input | CELLS | Per-cell gate select: 1 gates the enable with globalOe |
| outData | input | CELLS | Data from the logic block for each pin |
| ptOe | input | CELLS | Product-term driver enable for each pin |
| globalOe | input | 1 | Chip-wide output enable, active high |
| pad | inout | CELLS | Package pins, tri-state |
| padIn | output | CELLS | Pin levels returned to the routing fabric |

## Verification
On every clock the assertions compare the driver enable and driver value of each cell against a shadow copy of the loaded configuration. This covers four things: listen-only cells stay silent, the enable follows its selected source, push-pull drivers copy the data, and open-drain drivers present only a low level. Some behaviour can only be seen on the resolved net, so the bench scenarios show it. These are the external pull-up taking over a released open-drain pin, an outside driver pulling low against a data 1 with no contention, and the value returned on padIn for every role.

// File: rtl/io_cell_pkg.sv
`timescale 1ns/1ps
package io_cell_pkg;
  typedef enum logic [1:0] {
    MODE_SPARE = 2'b00,
    MODE_OUT   = 2'b01,
    MODE_BIDIR = 2'b10,
    MODE_IN    = 2'b11
  } padMode_e;

  // Strobes from control to datapath, one per cell
  typedef struct packed {
    logic driveEn;
    logic openDrain;
  } cellCtl_t;

  localparam logic [1:0] ERASED_MODE  = 2'b11;
  localparam logic       ERASED_TOTEM = 1'b1;
  localparam logic       ERASED_OESEL = 1'b1;
endpackage

// File: rtl/io_cell_ctrl.sv
`timescale 1ns/1ps
module io_cell_ctrl
  import io_cell_pkg::*;
#(
  parameter int CELLS = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgLoad,
  input  logic [2*CELLS-1:0]   cfgMode,
  input  logic [CELLS-1:0]     cfgTotem,
  input  logic [CELLS-1:0]     cfgOeSel,
  input  logic [CELLS-1:0]     ptOe,
  input  logic                 globalOe,
  output cellCtl_t [CELLS-1:0] ctl
);
  logic [CELLS-1:0][1:0] modeQ;
  logic [CELLS-1:0]      totemQ;
  logic [CELLS-1:0]      oeSelQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < CELLS; i++) begin
        modeQ[i]  <= ERASED_MODE;
        totemQ[i] <= ERASED_TOTEM;
        oeSelQ[i] <= ERASED_OESEL;
      end
    end else if (cfgLoad) begin
      for (int i = 0; i < CELLS; i++) begin
        modeQ[i]  <= cfgMode[2*i +: 2];
        totemQ[i] <= cfgTotem[i];
        oeSelQ[i] <= cfgOeSel[i];
      end
    end
  end

  for (genvar g = 0; g < CELLS; g++) begin : gCell
    logic gateOk;
    logic enable;
    assign gateOk = !oeSelQ[g] || globalOe;
    always_comb begin
      unique case (padMode_e'(modeQ[g]))
        MODE_OUT:   enable = gateOk;
        MODE_BIDIR: enable = gateOk && ptOe[g];
        default:    enable = 1'b0;
      endcase
    end
    assign ctl[g].driveEn   = enable;
    assign ctl[g].openDrain = !totemQ[g];
  end
endmodule

// File: rtl/io_cell_drv.sv
`timescale 1ns/1ps
module io_cell_drv
  import io_cell_pkg::*;
#(
  parameter int CELLS = 4
) (
  input  cellCtl_t [CELLS-1:0] ctl,
  input  logic [CELLS-1:0]     outData,
  output logic [CELLS-1:0]     padOut,
  output logic [CELLS-1:0]     padOe
);
  for (genvar g = 0; g < CELLS; g++) begin : gDrv
    // Open-drain: only a low level is ever presented; a one releases the net
    assign padOut[g] = ctl[g].openDrain ? 1'b0 : outData[g];
    assign padOe[g]  = ctl[g].driveEn && (!ctl[g].openDrain || !outData[g]);
  end
endmodule

// File: rtl/io_cell_bank.sv
`timescale 1ns/1ps
module io_cell_bank
  import io_cell_pkg::*;
#(
  parameter int CELLS = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgLoad,
  input  logic [2*CELLS-1:0]   cfgMode,
  input  logic [CELLS-1:0]     cfgTotem,
  input  logic [CELLS-1:0]     cfgOeSel,
  input  logic [CELLS-1:0]     outData,
  input  logic [CELLS-1:0]     ptOe,
  input  logic                 globalOe,
  inout  wire  [CELLS-1:0]     pad,
  output logic [CELLS-1:0]     padIn
);
  cellCtl_t [CELLS-1:0] ctl;
  logic [CELLS-1:0]     padOut;
  logic [CELLS-1:0]     padOe;

  io_cell_ctrl #(.CELLS(CELLS)) uCtrl (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgMode(cfgMode),
    .cfgTotem(cfgTotem), .cfgOeSel(cfgOeSel), .ptOe(ptOe),
    .globalOe(globalOe), .ctl(ctl)
  );

  io_cell_drv #(.CELLS(CELLS)) uDrv (
    .ctl(ctl), .outData(outData), .padOut(padOut), .padOe(padOe)
  );

  for (genvar g = 0; g < CELLS; g++) begin : gPad
    assign pad[g] = padOe[g] ? padOut[g] : 1'bz;
  end

  assign padIn = pad;
endmodule

// File: rtl/io_cell_bank_chk.sv
`timescale 1ns/1ps
module io_cell_bank_chk
  import io_cell_pkg::*;
#(
  parameter int CELLS = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               cfgLoad,
  input logic [2*CELLS-1:0] cfgMode,
  input logic [CELLS-1:0]   cfgTotem,
  input logic [CELLS-1:0]   cfgOeSel,
  input logic [CELLS-1:0]   outData,
  input logic [CELLS-1:0]   ptOe,
  input logic               globalOe,
  input logic [CELLS-1:0]   padOut,
  input logic [CELLS-1:0]   padOe
);
  logic [CELLS-1:0][1:0] shMode;
  logic [CELLS-1:0]      shTotem;
  logic [CELLS-1:0]      shOeSel;
  logic                  seenLoad;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shMode   <= '1;
      shTotem  <= '1;
      shOeSel  <= '1;
      seenLoad <= 1'b0;
    end else if (cfgLoad) begin
      for (int i = 0; i < CELLS; i++) shMode[i] <= cfgMode[2*i +: 2];
      shTotem  <= cfgTotem;
      shOeSel  <= cfgOeSel;
      seenLoad <= 1'b1;
    end
  end

  for (genvar g = 0; g < CELLS; g++) begin : gChk
    logic isListen, isOut, isBidir, gateOk;
    assign isListen = (shMode[g] == 2'b11) || (shMode[g] == 2'b00);
    assign isOut    = (shMode[g] == 2'b01);
    assign isBidir  = (shMode[g] == 2'b10);
    assign gateOk   = !shOeSel[g] || globalOe;

    a_r1_listen_silent: assert property (@(posedge clk) disable iff (!rstN)
      isListen |-> !padOe[g]);
    a_r2_out_drives: assert property (@(posedge clk) disable iff (!rstN)
      (isOut && gateOk && (shTotem[g] || !outData[g])) |-> padOe[g]);
    a_r3_bidir_enable: assert property (@(posedge clk) disable iff (!rstN)
      (isBidir && !ptOe[g]) |-> !padOe[g]);
    a_r4_totem_value: assert property (@(posedge clk) disable iff (!rstN)
      (shTotem[g] && padOe[g]) |-> (padOut[g] == outData[g]));
    a_r5_od_low_only: assert property (@(posedge clk) disable iff (!rstN)
      (!shTotem[g] && padOe[g]) |-> (padOut[g] == 1'b0));
    a_r6_gate_blocks: assert property (@(posedge clk) disable iff (!rstN)
      !gateOk |-> !padOe[g]);
    a_r8_erased_quiet: assert property (@(posedge clk) disable iff (!rstN)
      !seenLoad |-> !padOe[g]);
  end
endmodule

bind io_cell_bank io_cell_bank_chk #(.CELLS(CELLS)) uChk (
  .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgMode(cfgMode),
  .cfgTotem(cfgTotem), .cfgOeSel(cfgOeSel), .outData(outData),
  .ptOe(ptOe), .globalOe(globalOe), .padOut(padOut), .padOe(padOe)
);

// File: tb/io_cell_bank_test.sv
`timescale 1ns/1ps
module io_cell_bank_test;
  localparam int W = 4;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           cfgLoad = 1'b0;
  logic [2*W-1:0] cfgMode = '0;
  logic [W-1:0]   cfgTotem = '0;
  logic [W-1:0]   cfgOeSel = '0;
  logic [W-1:0]   outData = '0;
  logic [W-1:0]   ptOe = '0;
  logic           globalOe = 1'b0;
  logic [W-1:0]   tbEn = '0;
  logic [W-1:0]   tbVal = '0;
  wire  [W-1:0]   pad;
  logic [W-1:0]   padIn;

  // Bench's own view of the configuration that should be in force
  logic [2*W-1:0] shM = '1;
  logic [W-1:0]   shT = '1;
  logic [W-1:0]   shO = '1;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  for (genvar g = 0; g < W; g++) begin : gNet
    pullup pu (pad[g]);
    assign pad[g] = tbEn[g] ? tbVal[g] : 1'bz;
  end

  io_cell_bank #(.CELLS(W)) uut (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgMode(cfgMode),
    .cfgTotem(cfgTotem), .cfgOeSel(cfgOeSel), .outData(outData),
    .ptOe(ptOe), .globalOe(globalOe), .pad(pad), .padIn(padIn)
  );

  function automatic logic cellEnabled(int i);
    logic [1:0] m = shM[2*i +: 2];
    logic gate = !shO[i] || globalOe;
    if (m == 2'b01) return gate;
    if (m == 2'b10) return gate && ptOe[i];
    return 1'b0;
  endfunction

  function automatic logic cellDrives(int i);
    return cellEnabled(i) && (shT[i] || !outData[i]);
  endfunction

  function automatic logic expLevel(int i);
    if (cellDrives(i)) return shT[i] ? outData[i] : 1'b0;
    if (tbEn[i]) return tbVal[i];
    return 1'b1;
  endfunction

  task automatic checkAll(input string tag);
    for (int i = 0; i < W; i++) begin
      logic e = expLevel(i);
      checks++;
      if (padIn[i] !== e) begin
        failures++;
        $display("FAIL %s cell %0d actual=%b expected=%b", tag, i, padIn[i], e);
      end
    end
  endtask

  task automatic loadCfg(input logic [2*W-1:0] m, input logic [W-1:0] t,
                         input logic [W-1:0] o);
    @(negedge clk);
    cfgMode = m; cfgTotem = t; cfgOeSel = o; cfgLoad = 1'b1;
    @(negedge clk);
    cfgLoad = 1'b0;
    shM = m; shT = t; shO = o;
  endtask

  task automatic setIn(input logic [W-1:0] d, input logic [W-1:0] p,
                       input logic g, input logic [W-1:0] e, input logic [W-1:0] v);
    @(negedge clk);
    outData = d; ptOe = p; globalOe = g; tbEn = e; tbVal = v;
    #1;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog R1..R9 actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    // R8: during reset the erased setting leaves every pin to the pull-up
    outData = '1; ptOe = '1; globalOe = 1'b1; #7;
    checkAll("R8 reset pulled");
    tbEn = '1; tbVal = 4'b0101; #1;
    checkAll("R8 reset listen");
    @(negedge clk); rstN = 1'b1;
    setIn(4'b0000, 4'b1111, 1'b1, 4'b1111, 4'b1010);
    checkAll("R8 after reset");

    // R1: spare code 00 and listen code 11 never drive
    loadCfg(8'b00_11_00_11, 4'b1111, 4'b0000);
    setIn(4'b0000, 4'b1111, 1'b1, 4'b0000, 4'b0000);
    checkAll("R1 listen pulled");
    setIn(4'b1111, 4'b1111, 1'b1, 4'b1111, 4'b0110);
    checkAll("R1 R7 listen external");

    // R2/R4: drive-only push-pull ignores ptOe; gate select 0 ignores globalOe
    loadCfg(8'b01_01_01_01, 4'b1111, 4'b0000);
    setIn(4'b1001, 4'b0000, 1'b0, 4'b0000, 4'b0000);
    checkAll("R2 R4 out ungated");
    // R6: gate select 1 with globalOe low releases every cell
    loadCfg(8'b01_01_01_01, 4'b1111, 4'b1111);
    setIn(4'b0000, 4'b1111, 1'b0, 4'b0000, 4'b0000);
    checkAll("R6 gated off pulled");
    setIn(4'b0110, 4'b0000, 1'b1, 4'b0000, 4'b0000);
    checkAll("R2 gated on");

    // R3: two-way push-pull follows ptOe
    loadCfg(8'b10_10_10_10, 4'b1111, 4'b0000);
    setIn(4'b0000, 4'b0011, 1'b0, 4'b1100, 4'b0100);
    checkAll("R3 bidir ptOe");

    // R5: open-drain with data 1 releases; outside low wins with no contention
    loadCfg(8'b10_01_10_01, 4'b0000, 4'b0000);
    setIn(4'b1111, 4'b1111, 1'b0, 4'b1111, 4'b0000);
    checkAll("R5 od never high");
    setIn(4'b1111, 4'b1111, 1'b0, 4'b0000, 4'b0000);
    checkAll("R5 od pulled");
    setIn(4'b0000, 4'b1111, 1'b0, 4'b0000, 4'b0000);
    checkAll("R5 od low");
    // R6: open-drain cell disabled stays released even with data 0
    setIn(4'b0000, 4'b0000, 1'b0, 4'b1010, 4'b1010);
    checkAll("R6 od disabled");

    // R9: changing configuration inputs without cfgLoad leaves the pins alone
    @(negedge clk);
    cfgMode = 8'b11_11_11_11; cfgTotem = '1; cfgOeSel = '1;
    @(negedge clk); @(negedge clk);
    setIn(4'b0000, 4'b1111, 1'b0, 4'b0000, 4'b0000);
    checkAll("R9 hold");

    // Random mix
    for (int n = 0; n < 600; n++) begin
      logic [W-1:0] drvMask;
      if (($urandom % 4) == 0)
        loadCfg($urandom, $urandom, $urandom);
      @(negedge clk);
      outData = $urandom; ptOe = $urandom; globalOe = $urandom;
      drvMask = '0;
      for (int i = 0; i < W; i++) drvMask[i] = cellEnabled(i);
      tbEn = $urandom & ~drvMask;
      tbVal = $urandom;
      #1;
      checkAll("R4 R5 R7 random");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule